// File: doc/BRIEF.md
# Paged EEPROM I2C Slave Controller

This block is the I2C target side of a 256-byte, byte-wide nonvolatile array. The array is modelled as a register file of 16 pages, each 16 bytes long. The block takes the raw SCL and SDA lines and samples them with the system clock. It decodes a 7-bit device address: a fixed five-bit prefix followed by two strap pins. It answers page writes, current-address reads and random reads, and it keeps one 8-bit byte pointer that all three operations share.

Written bytes are first collected in a one-page holding buffer. They reach the array only when the host ends the transfer with STOP. A committed write then starts a simulated programming cycle of a parameterised length. While that cycle runs, the block refuses to acknowledge its own address, so the host can poll until the cycle ends. An active-low protect input stops every array update but leaves reads untouched.

The SDA output is open-drain: `sda_pull_o` high means the block pulls the line low. The host must not stretch SCL, and each SCL phase must last several system clocks.

Top module: `paged_nvm_i2c_slave`

## Requirements
- R1: After reset, SDA is released and every array byte reads 0xFF.
- R2: The block acknowledges only the address byte whose upper seven bits are 1010 0 followed by `dev_pins_i[1]` and then `dev_pins_i[0]`. Bit 0 of that byte is the direction: 0 means write, 1 means read. Any other address gets no acknowledge.
- R3: In a write, the first byte after the address sets the pointer. Each data byte after it is stored at the pointer. The low four pointer bits then advance and wrap inside the same 16-byte page, so bytes sent at 0x1F land at 0x1F and then at 0x10, and the pointer is left at 0x11.
- R4: If more than 16 data bytes are sent in one write, the later bytes overwrite the earlier ones at the same page offsets.
- R5: A read with no preceding pointer byte (current-address read) starts at the stored pointer, including a pointer left by a write. The pointer advances by one after every byte sent.
- R6: On reads the pointer runs across the whole array, crossing page boundaries and rolling from 0xFF to 0x00.
- R7: A random read, made of a write holding only the pointer byte, then a repeated START and a read, returns data from the new pointer and changes no array byte.
- R8: A STOP that ends a write with at least one data byte starts a programming cycle of `WRITE_CYCLES` clocks. During that cycle the block does not acknowledge its address. A write with no data byte starts no cycle.
- R9: While `wp_n_i` is low, written bytes are acknowledged but never reach the array, no programming cycle starts, and reads work normally.
- R10: Data bytes of a write that is cut short by a repeated START are discarded. They leave the array unchanged and start no programming cycle.
- R11: After the host answers a read byte with NACK, the block sends no more data on further SCL clocks and returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain driver enable) |
| dev_pins_i | input | 2 | Strap pins forming the two low device-address bits |
| wp_n_i | input | 1 | Active-low array write protect |

## Verification
The bench plays the host on a modelled open-drain wire. It first writes short bursts inside one page. It then writes bursts that start at a page's last byte, bursts longer than a page, and single bytes at the two ends of the array. Each burst is read back with both current-address and random reads. These patterns separate page-local write wrapping from array-wide read wrapping, and last-byte-wins overwriting from simple appending. The bench also polls the address right after STOP in five situations: a real write, a pointer-only write, a protected write, a write cut short by a repeated START, and a wrong strap address. These polls separate a true programming cycle from a spurious one. Extra SCL clocks after a master NACK show whether the block really stops sending.

// File: rtl/nvm_i2c_pkg.sv
// Shared constants and types for the paged EEPROM I2C slave.
// Assumes one-byte word addressing (8-bit pointer).
package nvm_i2c_pkg;

    // Fixed upper part of the 7-bit device address
    localparam logic [4:0] DEV_PREFIX = 5'b10100;

    // Byte-level link states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_DEV,
        ST_ACK_DEV,
        ST_RX_WADDR,
        ST_ACK_WADDR,
        ST_RX_DATA,
        ST_ACK_DATA,
        ST_TX_DATA,
        ST_RX_MACK
    } link_state_e;

endpackage

// File: rtl/i2c_line_sampler.sv
// Synchronises SCL/SDA into the clk domain and flags SCL edges, START and STOP.
// Assumes every bus phase lasts several clk cycles (no glitch filtering).
module i2c_line_sampler #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_sync_q, sda_sync_q;
    logic         scl_d_q, sda_d_q;

    // Synchroniser chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_d_q    <= 1'b1;
            sda_d_q    <= 1'b1;
        end else begin
            scl_sync_q <= {scl_sync_q[MSB-1:0], scl_i};
            sda_sync_q <= {sda_sync_q[MSB-1:0], sda_i};
            scl_d_q    <= scl_sync_q[MSB];
            sda_d_q    <= sda_sync_q[MSB];
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_s_o    = scl_sync_q[MSB];
        sda_s_o    = sda_sync_q[MSB];
        scl_rise_o = scl_s_o & ~scl_d_q;
        scl_fall_o = ~scl_s_o & scl_d_q;
        start_o    = scl_s_o & scl_d_q & sda_d_q & ~sda_s_o;
        stop_o     = scl_s_o & scl_d_q & ~sda_d_q & sda_s_o;
    end

endmodule

// File: rtl/nvm_page_store.sv
// Array model, one-page write buffer and programming-cycle timer.
// Buffered bytes reach the array only on commit with protect released.
// Assumes commit_i is the STOP pulse and clear_i the START pulse.
module nvm_page_store #(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned PAGE_W       = 4,
    parameter int unsigned WRITE_CYCLES = 1000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     commit_i,
    input  logic                     wp_n_i,
    input  logic                     page_we_i,
    input  logic [ADDR_W-PAGE_W-1:0] page_i,
    input  logic                     buf_we_i,
    input  logic [PAGE_W-1:0]        buf_idx_i,
    input  logic [7:0]               buf_data_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [7:0]               rd_data_o,
    output logic                     busy_o
);
    localparam int unsigned DEPTH      = 1 << ADDR_W;
    localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
    localparam int unsigned CW         = $clog2(WRITE_CYCLES + 1);

    logic [7:0]                mem_q [DEPTH];
    logic [7:0]                buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]     vld_q;
    logic [ADDR_W-PAGE_W-1:0]  page_q;
    logic [CW-1:0]             cyc_q;
    logic                      do_prog;

    assign do_prog   = commit_i & wp_n_i & (|vld_q);
    assign rd_data_o = mem_q[rd_addr_i];
    assign busy_o    = (cyc_q != '0);

    // Array: blank at reset, page merge on a committed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (do_prog) begin
            for (int j = 0; j < PAGE_BYTES; j++) begin
                if (vld_q[j]) mem_q[{page_q, PAGE_W'(j)}] <= buf_q[j];
            end
        end
    end

    // Holding buffer: filled per byte, emptied on START or STOP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            page_q <= '0;
            for (int j = 0; j < PAGE_BYTES; j++) buf_q[j] <= 8'h00;
        end else begin
            if (page_we_i) page_q <= page_i;
            if (clear_i || commit_i) begin
                vld_q <= '0;
            end else if (buf_we_i) begin
                buf_q[buf_idx_i] <= buf_data_i;
                vld_q[buf_idx_i] <= 1'b1;
            end
        end
    end

    // Programming-cycle down-counter
    always_ff @(posedge clk) begin
        if (!rst_n)          cyc_q <= '0;
        else if (do_prog)    cyc_q <= CW'(WRITE_CYCLES);
        else if (busy_o)     cyc_q <= cyc_q - 1'b1;
    end

    // R8: a STOP with buffered bytes and protect released starts the cycle
    p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && wp_n_i && vld_q != '0) |=> busy_o);

    // R9: a protected commit never starts a cycle
    p_wp_no_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !wp_n_i && !busy_o) |=> !busy_o);

    // R10: START empties the buffer, so a following STOP starts nothing
    p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !busy_o) |=> (vld_q == '0));

endmodule

// File: rtl/nvm_i2c_link.sv
// Byte-level I2C target: address decode, pointer handling, ACK and data
// shifting. Drives SDA only while SCL is low; relies on the sampler pulses.
module nvm_i2c_link
    import nvm_i2c_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_s_i,
    input  logic                     sda_s_i,
    input  logic                     scl_rise_i,
    input  logic                     scl_fall_i,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic [1:0]               dev_pins_i,
    input  logic                     busy_i,
    input  logic [7:0]               rd_data_i,
    output logic [ADDR_W-1:0]        rd_addr_o,
    output logic                     page_we_o,
    output logic [ADDR_W-PAGE_W-1:0] page_o,
    output logic                     buf_we_o,
    output logic [PAGE_W-1:0]        buf_idx_o,
    output logic [7:0]               buf_data_o,
    output logic                     sda_pull_o
);
    link_state_e       state_q;
    logic [3:0]        cnt_q;
    logic [7:0]        shreg_q;
    logic [7:0]        tx_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              drive_q;
    logic              mack_q;
    logic              byte_end;
    logic              dev_hit;

    assign byte_end   = scl_fall_i && (cnt_q == 4'd8);
    assign dev_hit    = (shreg_q[7:1] == {DEV_PREFIX, dev_pins_i});
    assign rd_addr_o  = ptr_q;
    assign page_we_o  = (state_q == ST_RX_WADDR) && byte_end;
    assign page_o     = shreg_q[7:PAGE_W];
    assign buf_we_o   = (state_q == ST_RX_DATA) && byte_end;
    assign buf_idx_o  = ptr_q[PAGE_W-1:0];
    assign buf_data_o = shreg_q;
    assign sda_pull_o = drive_q;

    // Protocol sequencer: bus conditions first, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            drive_q <= 1'b0;
            mack_q  <= 1'b0;
        end else if (stop_i) begin
            state_q <= ST_IDLE;
            drive_q <= 1'b0;
            cnt_q   <= '0;
        end else if (start_i) begin
            state_q <= ST_RX_DEV;
            drive_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_RX_DEV, ST_RX_WADDR, ST_RX_DATA: begin
                    if (scl_rise_i && cnt_q != 4'd8) begin
                        shreg_q <= {shreg_q[6:0], sda_s_i};
                        cnt_q   <= cnt_q + 1'b1;
                    end else if (byte_end) begin
                        cnt_q <= '0;
                        if (state_q == ST_RX_DEV) begin
                            if (dev_hit && !busy_i) begin
                                state_q <= ST_ACK_DEV;
                                drive_q <= 1'b1;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else if (state_q == ST_RX_WADDR) begin
                            ptr_q   <= shreg_q;
                            state_q <= ST_ACK_WADDR;
                            drive_q <= 1'b1;
                        end else begin
                            ptr_q   <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + 1'b1};
                            state_q <= ST_ACK_DATA;
                            drive_q <= 1'b1;
                        end
                    end
                end
                ST_ACK_DEV: begin
                    if (scl_fall_i) begin
                        if (shreg_q[0]) begin
                            tx_q    <= rd_data_i;
                            ptr_q   <= ptr_q + 1'b1;
                            drive_q <= ~rd_data_i[7];
                            cnt_q   <= '0;
                            state_q <= ST_TX_DATA;
                        end else begin
                            drive_q <= 1'b0;
                            state_q <= ST_RX_WADDR;
                        end
                    end
                end
                ST_ACK_WADDR, ST_ACK_DATA: begin
                    if (scl_fall_i) begin
                        drive_q <= 1'b0;
                        state_q <= ST_RX_DATA;
                    end
                end
                ST_TX_DATA: begin
                    if (scl_fall_i) begin
                        if (cnt_q == 4'd7) begin
                            drive_q <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= ST_RX_MACK;
                        end else begin
                            tx_q    <= {tx_q[6:0], 1'b0};
                            drive_q <= ~tx_q[6];
                            cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RX_MACK: begin
                    if (scl_rise_i) begin
                        mack_q <= ~sda_s_i;
                    end else if (scl_fall_i) begin
                        if (mack_q) begin
                            tx_q    <= rd_data_i;
                            ptr_q   <= ptr_q + 1'b1;
                            drive_q <= ~rd_data_i[7];
                            cnt_q   <= '0;
                            state_q <= ST_TX_DATA;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R8: the address is never acknowledged during a programming cycle
    p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_DEV) |-> !busy_i);

    // R2: entering the address ACK requires the strap-matched address
    p_ack_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK_DEV && $past(state_q) != ST_ACK_DEV) |-> dev_hit);

    // R3: accepting a data byte never moves the pointer to another page
    p_page_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we_o |=> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W])));

    // R11: STOP always leaves SDA released
    p_release_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !sda_pull_o);

    // R2: SDA is only ever pulled low while SCL is low
    p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_q) |-> !scl_s_i);

endmodule

// File: rtl/paged_nvm_i2c_slave.sv
// Top of the paged EEPROM I2C slave: sampler, byte link and page store.
// Assumes an 8-bit word pointer and no SCL stretching by the target.
module paged_nvm_i2c_slave #(
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned PAGE_W       = 4,
    parameter int unsigned WRITE_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [1:0] dev_pins_i,
    input  logic       wp_n_i
);
    logic                     scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic                     busy;
    logic [7:0]               rd_data;
    logic [ADDR_W-1:0]        rd_addr;
    logic                     page_we, buf_we;
    logic [ADDR_W-PAGE_W-1:0] page;
    logic [PAGE_W-1:0]        buf_idx;
    logic [7:0]               buf_data;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_p), .stop_o(stop_p)
    );

    nvm_i2c_link #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_p),
        .stop_i(stop_p), .dev_pins_i(dev_pins_i), .busy_i(busy),
        .rd_data_i(rd_data), .rd_addr_o(rd_addr), .page_we_o(page_we),
        .page_o(page), .buf_we_o(buf_we), .buf_idx_o(buf_idx),
        .buf_data_o(buf_data), .sda_pull_o(sda_pull_o)
    );

    nvm_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
                     .WRITE_CYCLES(WRITE_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .clear_i(start_p), .commit_i(stop_p),
        .wp_n_i(wp_n_i), .page_we_i(page_we), .page_i(page),
        .buf_we_i(buf_we), .buf_idx_i(buf_idx), .buf_data_i(buf_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy)
    );

endmodule

// File: tb/paged_nvm_i2c_slave_tb_top.sv
// Scoreboard bench: host tasks push expected values, a monitor compares.
module paged_nvm_i2c_slave_tb_top;
    localparam int WCYC = 1000;
    localparam int Q    = 4;
    localparam int H    = 8;
    localparam logic [7:0] DEV_W = 8'hA4;   // 1010 0 1 0 + write
    localparam logic [7:0] DEV_R = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp_n = 1'b1;
    logic sda_pull;
    logic sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #4 clk = ~clk;

    paged_nvm_i2c_slave #(.WRITE_CYCLES(WCYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .dev_pins_i(2'b10), .wp_n_i(wp_n)
    );

    typedef struct { string req; int val; } exp_t;
    exp_t exp_q[$];
    int   obs_val;
    event obs_ev;
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    logic [7:0] rexp [4];
    logic [7:0] wdat [18];

    // Monitor: pop one expectation per observation and compare
    always begin
        @(obs_ev);
        if (exp_q.size() == 0) begin
            n_fails++;
            $display("FAIL none: actual %0d expected nothing", obs_val);
        end else begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (e.val != obs_val) begin
                n_fails++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h", e.req, obs_val, e.val);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp_v);
        exp_t e;
        e.req = req; e.val = exp_v;
        exp_q.push_back(e);
        obs_val = act;
        -> obs_ev;
        @(negedge clk);
    endtask

    task automatic bus_start();
        repeat (H) @(negedge clk); sda_m = 1'b0;
        repeat (H) @(negedge clk); scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        repeat (Q) @(negedge clk); sda_m = 1'b1;
        repeat (Q) @(negedge clk); scl_m = 1'b1;
        repeat (H) @(negedge clk); sda_m = 1'b0;
        repeat (H) @(negedge clk); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        repeat (Q) @(negedge clk); sda_m = 1'b0;
        repeat (Q) @(negedge clk); scl_m = 1'b1;
        repeat (H) @(negedge clk); sda_m = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            repeat (Q) @(negedge clk); sda_m = b[i];
            repeat (Q) @(negedge clk); scl_m = 1'b1;
            repeat (H) @(negedge clk); scl_m = 1'b0;
        end
        repeat (Q) @(negedge clk); sda_m = 1'b1;
        repeat (Q) @(negedge clk); scl_m = 1'b1;
        repeat (Q) @(negedge clk); acked = !sda_line;
        repeat (Q) @(negedge clk); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            repeat (2 * Q) @(negedge clk); scl_m = 1'b1;
            repeat (Q) @(negedge clk); b[i] = sda_line;
            repeat (Q) @(negedge clk); scl_m = 1'b0;
        end
        repeat (Q) @(negedge clk); sda_m = !give_ack;
        repeat (Q) @(negedge clk); scl_m = 1'b1;
        repeat (H) @(negedge clk); scl_m = 1'b0;
        repeat (Q) @(negedge clk); sda_m = 1'b1;
    endtask

    // Address-only poll; returns whether the device answered
    task automatic poll(input string req, input bit exp_ack);
        bit a;
        bus_start(); send_byte(DEV_W, a); bus_stop();
        check(req, int'(a), int'(exp_ack));
    endtask

    // Page write of n bytes from wdat starting at addr
    task automatic write_seq(input string req, input logic [7:0] addr, input int n);
        bit a;
        bus_start();
        send_byte(DEV_W, a); check("R2", int'(a), 1);
        send_byte(addr, a);  check(req, int'(a), 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wdat[k], a); check(req, int'(a), 1);
        end
        bus_stop();
    endtask

    // Read of n bytes (random when rnd), compared with rexp; no stop
    task automatic read_seq(input string req, input bit rnd, input logic [7:0] addr, input int n);
        bit a;
        logic [7:0] d;
        bus_start();
        if (rnd) begin
            send_byte(DEV_W, a); check("R7", int'(a), 1);
            send_byte(addr, a);  check("R7", int'(a), 1);
            bus_rstart();
        end
        send_byte(DEV_R, a); check("R2", int'(a), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, d);
            check(req, int'(d), int'(rexp[k]));
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] d;
        int lows;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        check("R1", int'(sda_pull), 0);
        rexp[0] = 8'hFF;
        read_seq("R1", 1'b1, 8'h00, 1); bus_stop();

        // R2: wrong strap address is not acknowledged
        bus_start(); send_byte(8'hA0, a); bus_stop();
        check("R2", int'(a), 0);

        // R3/R8: page write, busy polling
        wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
        write_seq("R3", 8'h10, 3);
        poll("R8", 1'b0);
        repeat (WCYC + 100) @(negedge clk);
        poll("R8", 1'b1);
        rexp[0] = 8'h11; rexp[1] = 8'h22; rexp[2] = 8'h33; rexp[3] = 8'hFF;
        read_seq("R3", 1'b1, 8'h10, 4); bus_stop();

        // R3/R5: write from page top wraps to page base; pointer left at 0x11
        wdat[0] = 8'hAA; wdat[1] = 8'hBB;
        write_seq("R3", 8'h1F, 2);
        repeat (WCYC + 100) @(negedge clk);
        rexp[0] = 8'h22;
        read_seq("R5", 1'b0, 8'h00, 1); bus_stop();
        rexp[0] = 8'hAA; rexp[1] = 8'hFF;
        read_seq("R6", 1'b1, 8'h1F, 2); bus_stop();
        rexp[0] = 8'hBB;
        read_seq("R3", 1'b1, 8'h10, 1); bus_stop();

        // R4: 18 bytes into one page, last two overwrite offsets 0 and 1
        for (int k = 0; k < 18; k++) wdat[k] = 8'(8'h80 + k);
        write_seq("R4", 8'h40, 18);
        repeat (WCYC + 100) @(negedge clk);
        rexp[0] = 8'h90; rexp[1] = 8'h91; rexp[2] = 8'h82;
        read_seq("R4", 1'b1, 8'h40, 3);
        // R11: after NACK the next byte (0x83) must not appear
        lows = 0;
        for (int p = 0; p < 9; p++) begin
            repeat (2 * Q) @(negedge clk); scl_m = 1'b1;
            repeat (Q) @(negedge clk); if (!sda_line) lows++;
            repeat (Q) @(negedge clk); scl_m = 1'b0;
        end
        check("R11", lows, 0);
        check("R11", int'(sda_pull), 0);
        bus_stop();

        // R6: read rolls over from 0xFF to 0x00
        wdat[0] = 8'h5A; write_seq("R6", 8'hFF, 1);
        repeat (WCYC + 100) @(negedge clk);
        wdat[0] = 8'h3C; write_seq("R6", 8'h00, 1);
        repeat (WCYC + 100) @(negedge clk);
        rexp[0] = 8'h5A; rexp[1] = 8'h3C;
        read_seq("R6", 1'b1, 8'hFF, 2); bus_stop();

        // R7/R8: pointer-only write sets pointer, starts no cycle
        bus_start(); send_byte(DEV_W, a); send_byte(8'h50, a); bus_stop();
        poll("R8", 1'b1);
        rexp[0] = 8'hFF;
        read_seq("R7", 1'b0, 8'h00, 1); bus_stop();

        // R9: protected write is discarded, no cycle
        wp_n = 1'b0;
        wdat[0] = 8'h77; write_seq("R9", 8'h50, 1);
        poll("R9", 1'b1);
        rexp[0] = 8'hFF;
        read_seq("R9", 1'b1, 8'h50, 1); bus_stop();
        wp_n = 1'b1;

        // R10: write cut by repeated START is discarded
        bus_start();
        send_byte(DEV_W, a); send_byte(8'h60, a); send_byte(8'h12, a);
        check("R10", int'(a), 1);
        bus_rstart();
        send_byte(DEV_R, a); recv_byte(1'b0, d);
        check("R10", int'(d), 8'hFF);
        bus_stop();
        poll("R10", 1'b1);
        rexp[0] = 8'hFF;
        read_seq("R10", 1'b1, 8'h60, 1); bus_stop();

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule